// File: doc/BRIEF.md
# Modem Line Handshake Sequencer

This block brings a serial modem link up for one outbound transmission and tears it down afterwards. A start request raises the terminal-ready line (`dtr_o`). The block then works through the line conditions that the selected mode needs: loss of carrier, then the request-to-send line (`rts_o`), then data-set-ready, then the return of carrier, then clear-to-send. Each wait has its own tick-counted time limit. Only when every condition holds does it grant the data path to the transmitter. The grant lasts until the transmitter reports that it is done, and then both outgoing lines fall.

Three operating modes exist. Full duplex raises RTS at once and skips every carrier check. Half duplex first waits for the far end's carrier to drop, and only then raises RTS. After DSR it also waits for carrier to come back. Direct connection behaves like full duplex and never looks at the ring indicator. When ring sensing is enabled in the two modem modes, a start request is refused while the ring indicator is active.

Any timeout drops both outgoing lines and reports which wait failed. The report is kept until the next accepted start. All modem inputs pass through two synchronising flip-flops before the sequencer uses them. The time limits are counted in pulses of an external timebase tick.

Top module: `modem_line_seq`

## Requirements
- R1: After reset, `rts_o`, `dtr_o` and `grant_o` are low and `err_o` is 0.
- R2: An accepted start raises `dtr_o` at the next clock edge. In full duplex or direct mode, `rts_o` rises in that same cycle.
- R3: In half duplex, `rts_o` stays low while carrier is present. If carrier is still present on the DROP_TICKS-th tick, the attempt fails with `err_o` = 1.
- R4: With `rts_o` high, the block waits for DSR. If DSR is still absent on the CARRIER_TICKS-th tick of that wait, the attempt fails with `err_o` = 2.
- R5: In half duplex, after DSR the block waits for carrier to return. If carrier is still absent on the CARRIER_TICKS-th tick of that wait, the attempt fails with `err_o` = 3. No grant is given before carrier returns.
- R6: The block waits for CTS last. If CTS is still absent on the CTS_TICKS-th tick of that wait, the attempt fails with `err_o` = 4.
- R7: `grant_o` rises only after CTS has been seen. It stays high until a `tx_done_i` pulse, and both `rts_o` and `dtr_o` fall at the edge after that pulse.
- R8: A failure drives `rts_o`, `dtr_o` and `grant_o` low. The error code then stays unchanged until the next accepted start, which clears it to 0.
- R9: With `ci_sense_i` high, and outside direct mode, a start is ignored while the synchronised ring indicator is active. In direct mode the ring indicator has no effect.
- R10: In direct mode `half_duplex_i` is ignored, so no carrier condition is checked.
- R11: If a condition becomes true in the same cycle as the tick that would end its wait, the sequence proceeds and no error is raised.
- R12: A start request while a sequence is running is ignored, and so is a `tx_done_i` pulse outside the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request pulse |
| tx_done_i | input | 1 | Transmitter finished pulse |
| half_duplex_i | input | 1 | 1 selects half duplex, 0 selects full duplex |
| direct_i | input | 1 | 1 selects direct connection |
| ci_sense_i | input | 1 | Enables the ring-indicator check |
| tick_i | input | 1 | Timebase pulse for all time limits |
| dsr_i | input | 1 | Data set ready, active high, asynchronous |
| dcd_i | input | 1 | Carrier detect, active high, asynchronous |
| cts_i | input | 1 | Clear to send, active high, asynchronous |
| ci_i | input | 1 | Ring indicator, active high, asynchronous |
| rts_o | output | 1 | Request to send |
| dtr_o | output | 1 | Terminal ready |
| grant_o | output | 1 | Data path granted to the transmitter |
| err_o | output | 3 | 0 none, 1 carrier-drop, 2 DSR, 3 carrier-rise, 4 CTS timeout |

## Verification
The two events that can land in one cycle are a wait's condition becoming true and the tick that ends that wait. The bench first advances the CTS wait to one tick short of its limit. It then raises CTS two cycles before driving the final tick, so that the synchronised CTS and the tick reach the sequencer at the same edge; the expected result is a grant with error 0. A second run moves the tick one cycle earlier, and that run must end with error 4 and both lines low.

// File: rtl/modem_line_seq.sv
module modem_line_seq #(
  parameter int unsigned DROP_TICKS    = 5000,
  parameter int unsigned CARRIER_TICKS = 30000,
  parameter int unsigned CTS_TICKS     = 7000,
  localparam int unsigned MAX_A = (DROP_TICKS > CARRIER_TICKS) ? DROP_TICKS : CARRIER_TICKS,
  localparam int unsigned MAX_T = (MAX_A > CTS_TICKS) ? MAX_A : CTS_TICKS,
  localparam int unsigned CW    = $clog2(MAX_T + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       tx_done_i,
  input  logic       half_duplex_i,
  input  logic       direct_i,
  input  logic       ci_sense_i,
  input  logic       tick_i,
  input  logic       dsr_i,
  input  logic       dcd_i,
  input  logic       cts_i,
  input  logic       ci_i,
  output logic       rts_o,
  output logic       dtr_o,
  output logic       grant_o,
  output logic [2:0] err_o
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_DROP, ST_DSR, ST_RISE, ST_CTS, ST_SEND
  } st_t;

  localparam logic [2:0] E_NONE = 3'd0;
  localparam logic [2:0] E_DROP = 3'd1;
  localparam logic [2:0] E_DSR  = 3'd2;
  localparam logic [2:0] E_RISE = 3'd3;
  localparam logic [2:0] E_CTS  = 3'd4;

  st_t st, nxt;
  logic [3:0] m1, m2;
  logic [CW-1:0] cnt;
  logic half_q;
  logic [2:0] fail;
  int unsigned limit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m1 <= '0;
      m2 <= '0;
    end else begin
      m1 <= {ci_i, cts_i, dcd_i, dsr_i};
      m2 <= m1;
    end

  wire dsr_s = m2[0];
  wire dcd_s = m2[1];
  wire cts_s = m2[2];
  wire ci_s  = m2[3];

  wire ring_block = ci_sense_i && !direct_i && ci_s;
  wire accept     = (st == ST_IDLE) && start_i && !ring_block;
  wire half_new   = half_duplex_i && !direct_i;

  assign limit  = (st == ST_DROP) ? DROP_TICKS : (st == ST_CTS) ? CTS_TICKS : CARRIER_TICKS;
  wire   expire = tick_i && (cnt == CW'(limit - 1));

  always_comb begin
    nxt  = st;
    fail = E_NONE;
    unique case (st)
      ST_IDLE: if (accept) nxt = half_new ? ST_DROP : ST_DSR;
      ST_DROP: if (!dcd_s) nxt = ST_DSR;
               else if (expire) fail = E_DROP;
      ST_DSR:  if (dsr_s) nxt = half_q ? ST_RISE : ST_CTS;
               else if (expire) fail = E_DSR;
      ST_RISE: if (dcd_s) nxt = ST_CTS;
               else if (expire) fail = E_RISE;
      ST_CTS:  if (cts_s) nxt = ST_SEND;
               else if (expire) fail = E_CTS;
      ST_SEND: if (tx_done_i) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
    if (fail != E_NONE) nxt = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      half_q <= 1'b0;
      err_o  <= E_NONE;
    end else begin
      st <= nxt;
      if (nxt != st || st == ST_IDLE || st == ST_SEND) cnt <= '0;
      else if (tick_i) cnt <= cnt + 1'b1;
      if (accept) begin
        half_q <= half_new;
        err_o  <= E_NONE;
      end else if (fail != E_NONE) begin
        err_o  <= fail;
      end
    end

  assign dtr_o   = (st != ST_IDLE);
  assign rts_o   = (st == ST_DSR) || (st == ST_RISE) || (st == ST_CTS) || (st == ST_SEND);
  assign grant_o = (st == ST_SEND);

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !dtr_o |-> !rts_o && !grant_o);

  p_rts_after_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts_o) && half_q |-> !$past(dcd_s));

  p_timer_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) < int'(limit));

  p_grant_needs_cts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_o) |-> $past(cts_s));

  p_done_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o && tx_done_i |=> !rts_o && !dtr_o && !grant_o);

  p_fail_drops_lines_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o != E_NONE) |-> !rts_o && !dtr_o && !grant_o);

  p_err_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o != E_NONE) && !start_i |=> $stable(err_o));

  p_ring_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dtr_o && ci_sense_i && !direct_i && ci_s |=> !dtr_o);

endmodule

// File: tb/modem_line_seq_bench.sv
module modem_line_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int T_DROP = 4;
  localparam int T_CAR  = 6;
  localparam int T_CTS  = 3;

  logic clk = 0, rst_n = 0;
  logic start_i = 0, tx_done_i = 0, half_duplex_i = 0, direct_i = 0, ci_sense_i = 0, tick_i = 0;
  logic dsr_i = 0, dcd_i = 0, cts_i = 0, ci_i = 0;
  logic rts_o, dtr_o, grant_o;
  logic [2:0] err_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modem_line_seq #(.DROP_TICKS(T_DROP), .CARRIER_TICKS(T_CAR), .CTS_TICKS(T_CTS)) u_modem_line_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tx_done_i(tx_done_i),
    .half_duplex_i(half_duplex_i), .direct_i(direct_i), .ci_sense_i(ci_sense_i), .tick_i(tick_i),
    .dsr_i(dsr_i), .dcd_i(dcd_i), .cts_i(cts_i), .ci_i(ci_i),
    .rts_o(rts_o), .dtr_o(dtr_o), .grant_o(grant_o), .err_o(err_o));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();  start_i = 1;   cyc(1); start_i = 0;   endtask
  task automatic pulse_tick();   tick_i = 1;    cyc(1); tick_i = 0;    endtask
  task automatic pulse_done();   tx_done_i = 1; cyc(1); tx_done_i = 0; endtask

  task automatic setup(input bit half, input bit dir, input bit cis, input bit dsr, input bit dcd,
                       input bit cts, input bit ci);
    half_duplex_i = half; direct_i = dir; ci_sense_i = cis;
    dsr_i = dsr; dcd_i = dcd; cts_i = cts; ci_i = ci;
    cyc(4);
  endtask

  task automatic t_reset();
    check("R1 rts", rts_o, 0);
    check("R1 dtr", dtr_o, 0);
    check("R1 grant", grant_o, 0);
    check("R1 err", err_o, 0);
  endtask

  task automatic t_full_ok();
    setup(0, 0, 0, 1, 0, 1, 0);
    pulse_start();
    check("R2 dtr after start", dtr_o, 1);
    check("R2 rts with dtr", rts_o, 1);
    cyc(3);
    check("R7 grant", grant_o, 1);
    cyc(10);
    check("R7 grant held", grant_o, 1);
    start_i = 1; cyc(1); start_i = 0;
    check("R12 start in grant", grant_o, 1);
    pulse_done();
    check("R7 rts released", rts_o, 0);
    check("R7 dtr released", dtr_o, 0);
    check("R7 err clean", err_o, 0);
    pulse_done();
    check("R12 stray done", dtr_o, 0);
  endtask

  task automatic t_half_ok();
    setup(1, 0, 0, 1, 1, 1, 0);
    pulse_start();
    cyc(3);
    check("R3 dtr up", dtr_o, 1);
    check("R3 rts held low", rts_o, 0);
    dcd_i = 0; cyc(4);
    check("R3 rts after drop", rts_o, 1);
    check("R5 no grant without carrier", grant_o, 0);
    dcd_i = 1; cyc(5);
    check("R5 grant after carrier", grant_o, 1);
    pulse_done();
  endtask

  task automatic run_timeout(input string req, input int lim, input int code);
    pulse_start();
    cyc(4);
    for (int i = 0; i < lim - 1; i++) begin pulse_tick(); cyc(1); end
    check({req, " no early error"}, err_o, 0);
    check({req, " still active"}, dtr_o, 1);
    pulse_tick();
    check({req, " error code"}, err_o, code);
    check({req, " dtr low"}, dtr_o, 0);
    check({req, " rts low"}, rts_o, 0);
  endtask

  task automatic t_timeouts();
    setup(1, 0, 0, 1, 1, 1, 0);
    run_timeout("R3", T_DROP, 1);
    setup(0, 0, 0, 0, 0, 1, 0);
    run_timeout("R4", T_CAR, 2);
    setup(1, 0, 0, 1, 0, 1, 0);
    run_timeout("R5", T_CAR, 3);
    setup(0, 0, 0, 1, 0, 0, 0);
    run_timeout("R6", T_CTS, 4);
  endtask

  task automatic t_err_hold();
    cyc(10);
    check("R8 err held", err_o, 4);
    cts_i = 1; cyc(4);
    pulse_start();
    check("R8 err cleared on start", err_o, 0);
    cyc(3);
    pulse_done();
  endtask

  task automatic t_ring();
    setup(0, 0, 1, 1, 0, 1, 1);
    pulse_start(); cyc(3);
    check("R9 ring blocks start", dtr_o, 0);
    setup(0, 1, 1, 1, 0, 1, 1);
    pulse_start(); cyc(3);
    check("R9 direct ignores ring", grant_o, 1);
    pulse_done();
  endtask

  task automatic t_direct();
    setup(1, 1, 0, 1, 1, 1, 0);
    pulse_start();
    check("R10 rts at once", rts_o, 1);
    cyc(3);
    check("R10 grant ignoring carrier", grant_o, 1);
    pulse_done();
  endtask

  task automatic t_coincide();
    setup(0, 0, 0, 1, 0, 0, 0);
    pulse_start(); cyc(4);
    for (int i = 0; i < T_CTS - 1; i++) begin pulse_tick(); cyc(1); end
    cts_i = 1; cyc(2);
    pulse_tick();
    check("R11 grant on coincident tick", grant_o, 1);
    check("R11 no error", err_o, 0);
    pulse_done();
    setup(0, 0, 0, 1, 0, 0, 0);
    pulse_start(); cyc(4);
    for (int i = 0; i < T_CTS - 1; i++) begin pulse_tick(); cyc(1); end
    cts_i = 1; cyc(1);
    pulse_tick();
    check("R11 late cts times out", err_o, 4);
    check("R11 late cts lines low", dtr_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    t_reset();
    t_full_ok();
    t_half_ok();
    t_timeouts();
    t_err_hold();
    t_ring();
    t_direct();
    t_coincide();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule